// File: doc/BRIEF.md
# Platform Power State Sequencer

This block is a synchronous sequencer that walks a platform from fully unpowered (G3) to the working state (S0). Before anything else it holds the real-time-clock well in reset. That reset stays asserted until the clock-well supply has been present for a programmable number of clock ticks.

After that hold, the sequencer works through the supply rails in stages, and every stage waits for its own power-good handshake:

1. The always-on (suspend) rails are enabled one at a time.
2. The resume reset is released and the suspend clock is enabled. The sequencer then rests in S4/S5.
3. Two policy inputs decide whether it waits in S4/S5 for a wake event or moves on by itself.
4. The memory rail comes up and its power-good output is raised.
5. The core rails are enabled one at a time, and the core power-good outputs are raised.

A power-good input that does not arrive within a programmable number of cycles sends the sequencer to a sticky fault state. In that state every sequencing output returns to its reset value.

All rail, wake and clock-well supply inputs pass through two-flop synchronizers before they are used. The state code is exported so that the sequence can be observed.

Top module: `pwr_seq_top`

## Requirements
- R1: The clock-well reset and test outputs (active low) stay low until the synchronized clock-well supply input has been high for at least RTC_TICKS consecutive cycles. A low supply input clears the count, and the outputs return low within four cycles.
- R2: The suspend rail enables form a low-aligned thermometer. Bit 0 is enabled first, and bit i is enabled only after power-good bit i-1 of the suspend rails is seen. A later rail reporting good out of turn has no effect.
- R3: The rail sequence starts (state code 1) only after the clock-well reset is released. resume_rst_n rises only after every suspend power-good bit is high.
- R4: susp_clk_en is high only while resume_rst_n is high, and it rises one cycle after resume_rst_n rises.
- R5: In the S4/S5 rest state (state code 3), the sequencer proceeds on its own when pol_force_on=1 or pol_stay_off=0. Otherwise it waits for wake_evt.
- R6: Leaving S4/S5 first raises sleep_s4_n (state code 4). mem_pwr_good rises only after mem_pg is seen.
- R7: sleep_s3_n rises together with mem_pwr_good (state code 5). The core rail enables then form a low-aligned thermometer, stepped by the core power-good bits in index order.
- R8: core_pwr_good and mem_core_pwr_good rise only after every core power-good bit is high. The state code is then 6 (S0).
- R9: When a waited-for power-good input has not arrived after TMO_CYCLES cycles in one stage, the sequencer moves to state code 7. All sequencing outputs go low and fault goes high. Both conditions hold until rst_n, whatever the inputs do.
- R10: s0_entry is high for exactly one cycle each time S0 is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_supply_ok | input | 1 | Clock-well supply present (asynchronous) |
| sus_pg | input | N_SUS | Suspend rail power-good bits, bit 0 first in order |
| mem_pg | input | 1 | Memory rail power-good |
| core_pg | input | N_CORE | Core rail power-good bits, bit 0 first in order |
| wake_evt | input | 1 | Wake event request |
| pol_stay_off | input | 1 | Policy: remain in S4/S5 until wake |
| pol_force_on | input | 1 | Policy: proceed to S0 regardless |
| rtc_well_rst_n | output | 1 | Clock-well reset, active low |
| rtc_well_test_n | output | 1 | Clock-well test strap, active low |
| sus_en | output | N_SUS | Suspend rail enables |
| resume_rst_n | output | 1 | Resume reset, active low |
| susp_clk_en | output | 1 | Suspend clock enable |
| sleep_s4_n | output | 1 | Sleep-S4 request, active low |
| mem_pwr_good | output | 1 | Memory power-good |
| sleep_s3_n | output | 1 | Sleep-S3 request, active low |
| core_en | output | N_CORE | Core rail enables |
| core_pwr_good | output | 1 | Core power-good |
| mem_core_pwr_good | output | 1 | Memory-core power-good |
| s0_entry | output | 1 | One-cycle pulse on S0 entry |
| fault | output | 1 | Sticky timeout flag |
| state_code | output | 4 | 0 G3, 1 suspend ramp, 2 resume, 3 S4/S5, 4 memory, 5 core, 6 S0, 7 fault |

## Verification
The bench presents the suspend power-good bits out of order, to check that a later rail reporting good cannot skip ahead of rail 0. A sequencer that tested any bit instead of the indexed one would enable rails early.

It holds the S4/S5 state with no wake under the waiting policy, and it releases the state under both auto-start policy encodings. A wrong policy decode would either start on its own or hang.

It starves a suspend stage and, separately, the memory stage, to provoke the timeout. It then raises every power-good input to confirm that the fault does not clear without a reset.

It also checks that the clock-well reset is still low at the minimum tick count, and that it falls again when the supply drops. A short or ungated hold counter would fail one of these two checks.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_G3    = 3'd0,
    ST_SUS   = 3'd1,
    ST_RSM   = 3'd2,
    ST_S45   = 3'd3,
    ST_MEM   = 3'd4,
    ST_CORE  = 3'd5,
    ST_S0    = 3'd6,
    ST_FAULT = 3'd7
  } seq_state_t;

  // Low-aligned mask with n ones (n <= 15).
  function automatic logic [15:0] fill_mask(input int unsigned n);
    return 16'((32'h1 << n) - 32'h1);
  endfunction

  // Policy decode: proceed without wake when forced on or not told to stay off.
  function automatic logic auto_start(input logic stay_off, input logic force_on);
    return force_on | ~stay_off;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= '0;
      q_sync <= '0;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/pwr_rtc_hold.sv
module pwr_rtc_hold #(
  parameter int TICKS = 1800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_s,
  output logic hold_done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!supply_ok_s) cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign hold_done = (cnt == LAST);

  // R1: a missing supply forces the hold back on at the next edge
  p_supply_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_s |=> !hold_done);
  // R1: release only while the supply was present on the previous edge
  p_release_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_done) |-> $past(supply_ok_s));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
#(
  parameter int N_SUS      = 3,
  parameter int N_CORE     = 3,
  parameter int TMO_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_done,
  input  logic              pol_stay_off,
  input  logic              pol_force_on,
  input  logic [N_SUS-1:0]  sus_pg_s,
  input  logic              mem_pg_s,
  input  logic [N_CORE-1:0] core_pg_s,
  input  logic              wake_s,
  output logic [N_SUS-1:0]  sus_en,
  output logic              resume_rst_n,
  output logic              susp_clk_en,
  output logic              sleep_s4_n,
  output logic              mem_pwr_good,
  output logic              sleep_s3_n,
  output logic [N_CORE-1:0] core_en,
  output logic              core_pwr_good,
  output logic              mem_core_pwr_good,
  output logic              s0_entry,
  output logic              fault,
  output logic [3:0]        state_code
);
  localparam int NMAX = (N_SUS > N_CORE) ? N_SUS : N_CORE;
  localparam int IW   = $clog2(NMAX + 1);
  localparam int TW   = $clog2(TMO_CYCLES + 1);
  localparam logic [IW-1:0] SUS_LAST  = IW'(N_SUS - 1);
  localparam logic [IW-1:0] CORE_LAST = IW'(N_CORE - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYCLES - 1);

  seq_state_t    st, st_nx;
  logic [IW-1:0] idx, idx_nx;
  logic [TW-1:0] tmo;
  logic          waiting;
  logic          stage_timeout;
  logic          step_pg_sus, step_pg_core;
  logic [15:0]   step_mask;

  assign step_pg_sus   = sus_pg_s[idx];
  assign step_pg_core  = core_pg_s[idx];
  assign stage_timeout = waiting && (tmo == TMO_LAST);
  assign step_mask     = fill_mask(int'(idx) + 1);

  always_comb begin
    st_nx   = st;
    idx_nx  = idx;
    waiting = 1'b0;
    unique case (st)
      ST_G3:   if (rtc_done) begin st_nx = ST_SUS; idx_nx = '0; end
      ST_SUS:
        if (step_pg_sus) begin
          if (idx == SUS_LAST) st_nx = ST_RSM;
          else                 idx_nx = idx + 1'b1;
        end else waiting = 1'b1;
      ST_RSM:  st_nx = ST_S45;
      ST_S45:  if (auto_start(pol_stay_off, pol_force_on) || wake_s) st_nx = ST_MEM;
      ST_MEM:
        if (mem_pg_s) begin st_nx = ST_CORE; idx_nx = '0; end
        else waiting = 1'b1;
      ST_CORE:
        if (step_pg_core) begin
          if (idx == CORE_LAST) st_nx = ST_S0;
          else                  idx_nx = idx + 1'b1;
        end else waiting = 1'b1;
      default: ;
    endcase
    if (stage_timeout) st_nx = ST_FAULT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_G3;
      idx      <= '0;
      tmo      <= '0;
      s0_entry <= 1'b0;
    end else begin
      st       <= st_nx;
      idx      <= idx_nx;
      tmo      <= waiting ? tmo + 1'b1 : '0;
      s0_entry <= (st_nx == ST_S0) && (st != ST_S0);
    end
  end

  always_comb begin
    sus_en  = '0;
    core_en = '0;
    if (st == ST_SUS) sus_en = step_mask[N_SUS-1:0];
    else if (st inside {ST_RSM, ST_S45, ST_MEM, ST_CORE, ST_S0}) sus_en = '1;
    if (st == ST_CORE) core_en = step_mask[N_CORE-1:0];
    else if (st == ST_S0) core_en = '1;
  end

  assign resume_rst_n      = st inside {ST_RSM, ST_S45, ST_MEM, ST_CORE, ST_S0};
  assign susp_clk_en       = st inside {ST_S45, ST_MEM, ST_CORE, ST_S0};
  assign sleep_s4_n        = st inside {ST_MEM, ST_CORE, ST_S0};
  assign mem_pwr_good      = st inside {ST_CORE, ST_S0};
  assign sleep_s3_n        = st inside {ST_CORE, ST_S0};
  assign core_pwr_good     = (st == ST_S0);
  assign mem_core_pwr_good = (st == ST_S0);
  assign fault             = (st == ST_FAULT);
  assign state_code        = {1'b0, st};

  // R2: suspend enables stay a low-aligned thermometer
  p_sus_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sus_en & (sus_en + 1'b1)) == '0);
  // R7: core enables stay a low-aligned thermometer
  p_core_thermo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en & (core_en + 1'b1)) == '0);
  // R3: resume reset release follows all suspend rails good
  p_resume_after_sus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_rst_n) |-> $past(&sus_pg_s));
  // R4: suspend clock only under released resume reset
  p_clk_after_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_clk_en |-> resume_rst_n);
  p_clk_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_clk_en) |-> $past(resume_rst_n));
  // R6: memory good follows the memory rail handshake
  p_mem_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pwr_good) |-> $past(mem_pg_s) && sleep_s4_n);
  // R7: sleep-S3 released only with memory good
  p_s3_after_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_s3_n |-> mem_pwr_good);
  // R8: core good follows all core rails good
  p_core_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_good) |-> $past(&core_pg_s));
  // R9: fault is sticky and outputs stay at rest
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault && !resume_rst_n && sus_en == '0);
  // R10: S0 entry pulse is one cycle wide
  p_entry_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s0_entry |=> !s0_entry);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int N_SUS      = 3,
  parameter int N_CORE     = 3,
  parameter int RTC_TICKS  = 1800000,
  parameter int TMO_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_supply_ok,
  input  logic [N_SUS-1:0]  sus_pg,
  input  logic              mem_pg,
  input  logic [N_CORE-1:0] core_pg,
  input  logic              wake_evt,
  input  logic              pol_stay_off,
  input  logic              pol_force_on,
  output logic              rtc_well_rst_n,
  output logic              rtc_well_test_n,
  output logic [N_SUS-1:0]  sus_en,
  output logic              resume_rst_n,
  output logic              susp_clk_en,
  output logic              sleep_s4_n,
  output logic              mem_pwr_good,
  output logic              sleep_s3_n,
  output logic [N_CORE-1:0] core_en,
  output logic              core_pwr_good,
  output logic              mem_core_pwr_good,
  output logic              s0_entry,
  output logic              fault,
  output logic [3:0]        state_code
);
  localparam int SW = N_SUS + N_CORE + 3;

  logic [SW-1:0]     raw_in, sync_out;
  logic              rtc_ok_s, mem_pg_s, wake_s, rtc_done;
  logic [N_SUS-1:0]  sus_pg_s;
  logic [N_CORE-1:0] core_pg_s;

  assign raw_in = {rtc_supply_ok, mem_pg, wake_evt, core_pg, sus_pg};
  assign {rtc_ok_s, mem_pg_s, wake_s, core_pg_s, sus_pg_s} = sync_out;

  pwr_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(sync_out));

  pwr_rtc_hold #(.TICKS(RTC_TICKS)) u_rtc (
    .clk(clk), .rst_n(rst_n), .supply_ok_s(rtc_ok_s), .hold_done(rtc_done));

  assign rtc_well_rst_n  = rtc_done;
  assign rtc_well_test_n = rtc_done;

  pwr_fsm #(.N_SUS(N_SUS), .N_CORE(N_CORE), .TMO_CYCLES(TMO_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rtc_done(rtc_done),
    .pol_stay_off(pol_stay_off), .pol_force_on(pol_force_on),
    .sus_pg_s(sus_pg_s), .mem_pg_s(mem_pg_s), .core_pg_s(core_pg_s), .wake_s(wake_s),
    .sus_en(sus_en), .resume_rst_n(resume_rst_n), .susp_clk_en(susp_clk_en),
    .sleep_s4_n(sleep_s4_n), .mem_pwr_good(mem_pwr_good), .sleep_s3_n(sleep_s3_n),
    .core_en(core_en), .core_pwr_good(core_pwr_good),
    .mem_core_pwr_good(mem_core_pwr_good), .s0_entry(s0_entry),
    .fault(fault), .state_code(state_code));

  // R3: no rail is enabled while the clock well is still held
  p_seq_after_rtc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_en[0]) |-> rtc_well_rst_n);
endmodule

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;
  localparam int N_SUS = 3, N_CORE = 2, RTC_TICKS = 20, TMO_CYCLES = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rtc_supply_ok = 1'b0, mem_pg = 1'b0, wake_evt = 1'b0;
  logic pol_stay_off = 1'b1, pol_force_on = 1'b0;
  logic [N_SUS-1:0] sus_pg = '0;
  logic [N_CORE-1:0] core_pg = '0;
  logic rtc_well_rst_n, rtc_well_test_n, resume_rst_n, susp_clk_en, sleep_s4_n;
  logic mem_pwr_good, sleep_s3_n, core_pwr_good, mem_core_pwr_good, s0_entry, fault;
  logic [N_SUS-1:0] sus_en;
  logic [N_CORE-1:0] core_en;
  logic [3:0] state_code;

  int nvec = 0, nerr = 0, pulse_cnt = 0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(.N_SUS(N_SUS), .N_CORE(N_CORE), .RTC_TICKS(RTC_TICKS),
                .TMO_CYCLES(TMO_CYCLES)) dut (.*);

  always @(negedge clk)
    if (!rst_n) pulse_cnt <= 0;
    else if (s0_entry) pulse_cnt <= pulse_cnt + 1;

  // inputs {rtc, sus[2:0], mem, core[1:0], wake, stay_off, force_on}
  // expect {code[3:0], sus_en[2:0], core_en[1:0], resume, clk_en, s4_n, s3_n, mem_good, core_good}
  typedef struct packed { logic [9:0] stim; logic [14:0] expv; } vec_t;
  localparam vec_t VEC [9] = '{
    '{10'b1_110_0_00_0_10, 15'b0001_001_00_000000},
    '{10'b1_001_0_00_0_10, 15'b0001_011_00_000000},
    '{10'b1_011_0_00_0_10, 15'b0001_111_00_000000},
    '{10'b1_111_0_00_0_10, 15'b0011_111_00_110000},
    '{10'b1_111_0_00_0_10, 15'b0011_111_00_110000},
    '{10'b1_111_0_00_1_10, 15'b0100_111_00_111000},
    '{10'b1_111_1_00_0_10, 15'b0101_111_01_111110},
    '{10'b1_111_1_01_0_10, 15'b0101_111_11_111110},
    '{10'b1_111_1_11_0_10, 15'b0110_111_11_111111}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R3/R4";
      4:       return "R5";
      5:       return "R6";
      6, 7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {rtc_supply_ok, sus_pg, mem_pg, core_pg, wake_evt} = '0;
    pol_stay_off = 1'b1; pol_force_on = 1'b0;
    cycles(3);
    // Reset state
    check("R3 reset", {state_code, sus_en, core_en, resume_rst_n, susp_clk_en, sleep_s4_n,
          sleep_s3_n, mem_pwr_good, core_pwr_good, fault, rtc_well_rst_n}, '0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: clock-well hold counts RTC_TICKS before release
    rtc_supply_ok = 1'b1;
    cycles(RTC_TICKS - 1);
    check("R1 hold", {rtc_well_rst_n, rtc_well_test_n, state_code}, 0);
    cycles(4);
    check("R1 release", {rtc_well_rst_n, rtc_well_test_n, state_code}, {2'b11, 4'd1});

    for (int i = 0; i < 9; i++) begin
      {rtc_supply_ok, sus_pg, mem_pg, core_pg, wake_evt, pol_stay_off, pol_force_on} = VEC[i].stim;
      cycles(6);
      check(vec_req(i), {state_code, sus_en, core_en, resume_rst_n, susp_clk_en, sleep_s4_n,
            sleep_s3_n, mem_pwr_good, core_pwr_good}, VEC[i].expv);
    end
    check("R8 mem_core", mem_core_pwr_good, 1);
    check("R10 pulse", pulse_cnt, 1);

    // R1: supply drop reasserts the clock-well reset
    rtc_supply_ok = 1'b0;
    cycles(4);
    check("R1 drop", {rtc_well_rst_n, rtc_well_test_n}, 0);

    // R5: auto start with stay_off=0
    do_reset();
    pol_stay_off = 1'b0; sus_pg = '1; rtc_supply_ok = 1'b1;
    cycles(RTC_TICKS + 12);
    check("R5 auto stay0", state_code, 4);
    // R5: auto start with force_on=1 even when stay_off=1
    do_reset();
    pol_force_on = 1'b1; sus_pg = '1; rtc_supply_ok = 1'b1;
    cycles(RTC_TICKS + 12);
    check("R5 auto force", state_code, 4);

    // R9: starved suspend rail times out and stays faulted
    do_reset();
    rtc_supply_ok = 1'b1;
    cycles(RTC_TICKS + TMO_CYCLES + 10);
    check("R9 sus timeout", {state_code, fault, sus_en, resume_rst_n}, {4'd7, 1'b1, 4'b0});
    sus_pg = '1; mem_pg = 1'b1; core_pg = '1; wake_evt = 1'b1;
    cycles(10);
    check("R9 sticky", {state_code, fault, sus_en, susp_clk_en}, {4'd7, 1'b1, 4'b0});

    // R9: starved memory rail times out
    do_reset();
    pol_stay_off = 1'b0; sus_pg = '1; rtc_supply_ok = 1'b1;
    cycles(RTC_TICKS + TMO_CYCLES + 20);
    check("R9 mem timeout", {state_code, fault, sleep_s4_n, resume_rst_n}, {4'd7, 1'b1, 2'b0});
    check("R10 no pulse", pulse_cnt, 0);

    do_reset();
    finish_run();
  end
endmodule